// File: doc/BRIEF.md
# Memory-Card Host Control and Interrupt Router

This block is the control side of a memory-card host controller that sits on a 32-bit register bus. It stores the settings a command needs: the card clock divider, the SPI mode field, the command/data configuration word, the response and read timeouts, block size and block count, the command index and the 32-bit argument. It also keeps a status word and a sticky interrupt request vector, and it works out when a card command is launched. The data FIFOs, response capture and the card-side line drivers sit in a neighbouring data path. That data path receives the launch and abort pulses and the configuration fields. It reports events back through set vectors, and the FIFO and response offsets are forwarded to it as strobes.

A command can launch from two register writes. The first is a write of the configuration word while the card clock runs. The second is a clock-start write while a command is still pending. In both cases the stop-transfer bit must be clear. Request bits go to one processor interrupt line. When the configuration word enables DMA, the receive and transmit FIFO request bits leave the processor interrupt and drive two DMA request lines instead.

Top module: `card_host_ctrl`

## Requirements
- R1: After reset every stored register reads zero, the card clock is off, and irq, dma_rx_req and dma_tx_req are low.
- R2: Stored writes are truncated to each field width: clock divider 3 bits (0x08), SPI field 4 bits (0x0C), configuration word ANDed with 0x3DFF (0x10), response timeout 7 bits (0x14), read timeout 16 bits (0x18), block length 12 bits (0x1C), block count 16 bits (0x20), interrupt mask 13 bits (0x28), command index 6 bits (0x30). Each reads back as stored.
- R3: Offset 0x34 replaces argument bits 31:16 and 0x38 replaces bits 15:0, each from wdata[15:0], and each reads back its own half. The command index reads back ORed with 0x40. Offset 0x4C reads the block count. Offsets 0x00, 0x24 and 0x48 read zero. Any unmapped offset reads zero. Writes to unmapped or read-only offsets (0x04, 0x2C, 0x4C, and offsets above 0x4C) change nothing.
- R4: A write to 0x00 with bit 1 set sets status bit 8 (clock running) and clears request bit 4 (clock off).
- R5: A write to 0x00 with bit 0 set clears status bit 8, sets request bit 4 and pulses xfer_abort. When bits 0 and 1 are both set, the clock ends stopped.
- R6: Every write to 0x10 pulses xfer_abort and marks a command pending. If the new word has bit 10 (stop transfer) clear, the status keeps only bit 8, and if the clock runs, cmd_go pulses in the same cycle. Issuing clears the pending mark.
- R7: A clock-start write pulses cmd_go in the same cycle only when a command is pending and the stored configuration bit 10 is clear. It then also clears every status bit except bit 8.
- R8: irq is high exactly when some request bit is set whose mask bit is clear.
- R9: With configuration bit 7 (DMA enable) set, request bits 5 (receive) and 6 (transmit) are excluded from irq and appear on dma_rx_req and dma_tx_req. With bit 7 clear, both DMA lines stay low.
- R10: A read of 0x40 strobes fifo_rx_rd, returns fifo_rx_data and clears request bit 5. A write of 0x44 strobes fifo_tx_wr and clears request bit 6. A read of 0x3C strobes resp_rd and returns resp_data. fifo_size follows bus_size.
- R11: dp_stat_set bits (other than bit 8) and dp_irq_set bits are ORed into status and request on the next edge, and they win over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | Access width code for FIFO accesses |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during bus_rd |
| fifo_rx_rd | output | 1 | Receive FIFO read strobe |
| fifo_tx_wr | output | 1 | Transmit FIFO write strobe |
| fifo_size | output | 2 | Access width passed to the FIFOs |
| fifo_rx_data | input | DATA_W | Receive FIFO read data |
| resp_rd | output | 1 | Response FIFO read strobe |
| resp_data | input | 16 | Response FIFO read data |
| dp_stat_set | input | STAT_W | Status bits to set from the data path |
| dp_irq_set | input | IRQ_W | Request bits to set from the data path |
| cmd_go | output | 1 | Command launch pulse |
| xfer_abort | output | 1 | Abort of the active transfer |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_cfg | output | 14 | Command/data configuration word |
| blk_len | output | 12 | Block length |
| blk_cnt | output | 16 | Block count |
| clk_div | output | 3 | Card clock divider |
| rsp_tmo | output | 7 | Response timeout |
| rd_tmo | output | 16 | Read timeout |
| irq | output | 1 | Processor interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its default parameters: a 7-bit offset, a 32-bit data bus, a 13-bit request vector and a 16-bit status word. These sizes include both DMA-routed request bits, the clock-off bit and the top mask bit. They also cover every offset up to the blocks-remaining register and the unmapped offsets above it. Both launch paths, the stop-transfer gate and the combined start-and-stop write are therefore exercised, along with random mask and request patterns.

// File: rtl/chc_pkg.sv
`timescale 1ns/1ps
package chc_pkg;
  localparam logic [6:0] OFF_CLKCTL = 7'h00;
  localparam logic [6:0] OFF_STAT   = 7'h04;
  localparam logic [6:0] OFF_CLKDIV = 7'h08;
  localparam logic [6:0] OFF_SPI    = 7'h0C;
  localparam logic [6:0] OFF_CFG    = 7'h10;
  localparam logic [6:0] OFF_RSPTMO = 7'h14;
  localparam logic [6:0] OFF_RDTMO  = 7'h18;
  localparam logic [6:0] OFF_BLKLEN = 7'h1C;
  localparam logic [6:0] OFF_BLKCNT = 7'h20;
  localparam logic [6:0] OFF_PART   = 7'h24;
  localparam logic [6:0] OFF_IMASK  = 7'h28;
  localparam logic [6:0] OFF_IREQ   = 7'h2C;
  localparam logic [6:0] OFF_CMDIDX = 7'h30;
  localparam logic [6:0] OFF_ARGHI  = 7'h34;
  localparam logic [6:0] OFF_ARGLO  = 7'h38;
  localparam logic [6:0] OFF_RESP   = 7'h3C;
  localparam logic [6:0] OFF_RXF    = 7'h40;
  localparam logic [6:0] OFF_TXF    = 7'h44;
  localparam logic [6:0] OFF_RDWAIT = 7'h48;
  localparam logic [6:0] OFF_BLKREM = 7'h4C;

  localparam int CTL_STOP_BIT  = 0;
  localparam int CTL_START_BIT = 1;
  localparam int ST_CLKON_BIT  = 8;
  localparam int CFG_DMA_BIT   = 7;
  localparam int CFG_HALT_BIT  = 10;
  localparam int RQ_CLKOFF_BIT = 4;
  localparam int RQ_RX_BIT     = 5;
  localparam int RQ_TX_BIT     = 6;
  localparam logic [13:0] CFG_KEEP = 14'h3DFF;
  localparam logic [5:0]  IDX_READ_OR = 6'h00;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [13:0] cfg;
    logic [11:0] blk_len;
    logic [15:0] blk_cnt;
    logic [2:0]  clk_div;
    logic [3:0]  spi;
    logic [6:0]  rsp_tmo;
    logic [15:0] rd_tmo;
  } host_cfg_t;
endpackage

// File: rtl/chc_cfg_regs.sv
`timescale 1ns/1ps
module chc_cfg_regs
  import chc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output host_cfg_t         cfg_q
);
  host_cfg_t cfg_d;
  logic      cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (wr) begin
      cfg_en = 1'b1;
      case (7'(addr))
        OFF_CLKDIV: cfg_d.clk_div  = wdata[2:0];
        OFF_SPI:    cfg_d.spi      = wdata[3:0];
        OFF_CFG:    cfg_d.cfg      = wdata[13:0] & CFG_KEEP;
        OFF_RSPTMO: cfg_d.rsp_tmo  = wdata[6:0];
        OFF_RDTMO:  cfg_d.rd_tmo   = wdata[15:0];
        OFF_BLKLEN: cfg_d.blk_len  = wdata[11:0];
        OFF_BLKCNT: cfg_d.blk_cnt  = wdata[15:0];
        OFF_CMDIDX: cfg_d.idx      = wdata[5:0];
        OFF_ARGHI:  cfg_d.arg[31:16] = wdata[15:0];
        OFF_ARGLO:  cfg_d.arg[15:0]  = wdata[15:0];
        default:    cfg_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/chc_seq.sv
`timescale 1ns/1ps
module chc_seq
  import chc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_halt,
  input  logic [STAT_W-1:0] stat_set,
  output logic [STAT_W-1:0] status_q,
  output logic              pending_q,
  output logic              clk_on,
  output logic              cmd_go,
  output logic              xfer_abort,
  output logic              clk_started,
  output logic              clk_stopped
);
  localparam logic [STAT_W-1:0] KEEP_CLK = STAT_W'(1) << ST_CLKON_BIT;

  logic [STAT_W-1:0] status_d;
  logic              pending_d;
  logic              ctl_wr, cfg_wr;

  assign ctl_wr = wr && (7'(addr) == OFF_CLKCTL);
  assign cfg_wr = wr && (7'(addr) == OFF_CFG);
  assign clk_on = status_q[ST_CLKON_BIT];

  always_comb begin
    status_d    = status_q;
    pending_d   = pending_q;
    cmd_go      = 1'b0;
    xfer_abort  = 1'b0;
    clk_started = 1'b0;
    clk_stopped = 1'b0;
    if (ctl_wr) begin
      if (wdata[CTL_START_BIT]) begin
        clk_started = 1'b1;
        status_d[ST_CLKON_BIT] = 1'b1;
        if (pending_q && !cur_halt) begin
          status_d  = status_d & KEEP_CLK;
          cmd_go    = 1'b1;
          pending_d = 1'b0;
        end
      end
      if (wdata[CTL_STOP_BIT]) begin
        clk_stopped = 1'b1;
        status_d[ST_CLKON_BIT] = 1'b0;
        xfer_abort = 1'b1;
      end
    end else if (cfg_wr) begin
      xfer_abort = 1'b1;
      pending_d  = 1'b1;
      if (!wdata[CFG_HALT_BIT]) begin
        status_d = status_q & KEEP_CLK;
        if (clk_on) begin
          cmd_go    = 1'b1;
          pending_d = 1'b0;
        end
      end
    end
    status_d = status_d | (stat_set & ~KEEP_CLK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      status_q  <= status_d;
      pending_q <= pending_d;
    end
  end
endmodule

// File: rtl/chc_irq_route.sv
`timescale 1ns/1ps
module chc_irq_route
  import chc_pkg::*;
#(
  parameter int IRQ_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] ext_set,
  input  logic             set_clkoff,
  input  logic             clr_clkoff,
  input  logic             clr_rx,
  input  logic             clr_tx,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             dma_en,
  output logic [IRQ_W-1:0] req_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq,
  output logic             dma_rx_req,
  output logic             dma_tx_req
);
  localparam logic [IRQ_W-1:0] DMA_BITS =
    (IRQ_W'(1) << RQ_RX_BIT) | (IRQ_W'(1) << RQ_TX_BIT);

  logic [IRQ_W-1:0] set_all, clr_all, req_d, eff_mask;

  always_comb begin
    set_all = ext_set;
    clr_all = '0;
    set_all[RQ_CLKOFF_BIT] = ext_set[RQ_CLKOFF_BIT] | set_clkoff;
    clr_all[RQ_CLKOFF_BIT] = clr_clkoff;
    clr_all[RQ_RX_BIT]     = clr_rx;
    clr_all[RQ_TX_BIT]     = clr_tx;
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_req
    assign req_d[b] = set_all[b] | (req_q[b] & ~clr_all[b]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[b] <= 1'b0;
      else        req_q[b] <= req_d[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign eff_mask   = mask_q | (dma_en ? DMA_BITS : '0);
  assign irq        = |(req_q & ~eff_mask);
  assign dma_rx_req = dma_en & req_q[RQ_RX_BIT];
  assign dma_tx_req = dma_en & req_q[RQ_TX_BIT];
endmodule

// File: rtl/card_host_ctrl.sv
`timescale 1ns/1ps
module card_host_ctrl
  import chc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 13,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fifo_rx_rd,
  output logic              fifo_tx_wr,
  output logic [1:0]        fifo_size,
  input  logic [DATA_W-1:0] fifo_rx_data,
  output logic              resp_rd,
  input  logic [15:0]       resp_data,
  input  logic [STAT_W-1:0] dp_stat_set,
  input  logic [IRQ_W-1:0]  dp_irq_set,
  output logic              cmd_go,
  output logic              xfer_abort,
  output logic [5:0]        cmd_index,
  output logic [31:0]       cmd_arg,
  output logic [13:0]       cmd_cfg,
  output logic [11:0]       blk_len,
  output logic [15:0]       blk_cnt,
  output logic [2:0]        clk_div,
  output logic [6:0]        rsp_tmo,
  output logic [15:0]       rd_tmo,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);
  host_cfg_t         cfg_q;
  logic [STAT_W-1:0] status_q;
  logic [IRQ_W-1:0]  req_q, mask_q;
  logic              cmd_pending, clk_on, clk_started, clk_stopped;
  logic [6:0]        off;

  assign off = 7'(bus_addr);

  chc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfg (
    .clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cfg_q
  );

  chc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) i_seq (
    .clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cur_halt(cfg_q.cfg[CFG_HALT_BIT]), .stat_set(dp_stat_set),
    .status_q, .pending_q(cmd_pending), .clk_on, .cmd_go, .xfer_abort,
    .clk_started, .clk_stopped
  );

  chc_irq_route #(.IRQ_W(IRQ_W)) i_irq (
    .clk, .rst_n, .ext_set(dp_irq_set),
    .set_clkoff(clk_stopped), .clr_clkoff(clk_started),
    .clr_rx(fifo_rx_rd), .clr_tx(fifo_tx_wr),
    .mask_wr(bus_wr && off == OFF_IMASK), .mask_wdata(bus_wdata[IRQ_W-1:0]),
    .dma_en(cfg_q.cfg[CFG_DMA_BIT]),
    .req_q, .mask_q, .irq, .dma_rx_req, .dma_tx_req
  );

  assign fifo_rx_rd = bus_rd && off == OFF_RXF;
  assign fifo_tx_wr = bus_wr && off == OFF_TXF;
  assign resp_rd    = bus_rd && off == OFF_RESP;
  assign fifo_size  = bus_size;

  assign cmd_index = cfg_q.idx;
  assign cmd_arg   = cfg_q.arg;
  assign cmd_cfg   = cfg_q.cfg;
  assign blk_len   = cfg_q.blk_len;
  assign blk_cnt   = cfg_q.blk_cnt;
  assign clk_div   = cfg_q.clk_div;
  assign rsp_tmo   = cfg_q.rsp_tmo;
  assign rd_tmo    = cfg_q.rd_tmo;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (off)
        OFF_STAT:   bus_rdata = DATA_W'(status_q);
        OFF_CLKDIV: bus_rdata = DATA_W'(cfg_q.clk_div);
        OFF_SPI:    bus_rdata = DATA_W'(cfg_q.spi);
        OFF_CFG:    bus_rdata = DATA_W'(cfg_q.cfg);
        OFF_RSPTMO: bus_rdata = DATA_W'(cfg_q.rsp_tmo);
        OFF_RDTMO:  bus_rdata = DATA_W'(cfg_q.rd_tmo);
        OFF_BLKLEN: bus_rdata = DATA_W'(cfg_q.blk_len);
        OFF_BLKCNT: bus_rdata = DATA_W'(cfg_q.blk_cnt);
        OFF_BLKREM: bus_rdata = DATA_W'(cfg_q.blk_cnt);
        OFF_IMASK:  bus_rdata = DATA_W'(mask_q);
        OFF_IREQ:   bus_rdata = DATA_W'(req_q);
        OFF_CMDIDX: bus_rdata = DATA_W'({1'b1, cfg_q.idx | IDX_READ_OR});
        OFF_ARGHI:  bus_rdata = DATA_W'(cfg_q.arg[31:16]);
        OFF_ARGLO:  bus_rdata = DATA_W'(cfg_q.arg[15:0]);
        OFF_RESP:   bus_rdata = DATA_W'(resp_data);
        OFF_RXF:    bus_rdata = fifo_rx_data;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/chc_checker.sv
`timescale 1ns/1ps
module chc_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cmd_go,
  input logic              xfer_abort,
  input logic              clk_on,
  input logic              cmd_pending,
  input logic [13:0]       cmd_cfg,
  input logic              dma_rx_req,
  input logic              dma_tx_req
);
  p_dma_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cfg[7] |-> (!dma_rx_req && !dma_tx_req));

  p_stop_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 7'(bus_addr) == 7'h00 && bus_wdata[0]) |=> !clk_on);

  p_start_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 7'(bus_addr) == 7'h00 && bus_wdata[1] && !bus_wdata[0]) |=> clk_on);

  p_cfg_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 7'(bus_addr) == 7'h10) |-> xfer_abort);

  p_issue_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_pending);

  p_go_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (bus_wr && (7'(bus_addr) == 7'h00 || 7'(bus_addr) == 7'h10)));
endmodule

bind card_host_ctrl chc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmd_go(cmd_go), .xfer_abort(xfer_abort),
  .clk_on(clk_on), .cmd_pending(cmd_pending), .cmd_cfg(cmd_cfg),
  .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
);

// File: tb/test_card_host_ctrl.sv
`timescale 1ns/1ps
module test_card_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fifo_rx_rd, fifo_tx_wr, resp_rd;
  logic [1:0]  fifo_size;
  logic [31:0] fifo_rx_data = 32'hA5A5_1234;
  logic [15:0] resp_data = 16'hBEEF;
  logic [15:0] dp_stat_set = '0;
  logic [12:0] dp_irq_set = '0;
  logic        cmd_go, xfer_abort;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [13:0] cmd_cfg;
  logic [11:0] blk_len;
  logic [15:0] blk_cnt, rd_tmo;
  logic [2:0]  clk_div;
  logic [6:0]  rsp_tmo;
  logic        irq, dma_rx_req, dma_tx_req;

  int checks = 0, errors = 0;
  logic got_go, got_abort, got_txwr, got_rxrd, got_resprd;
  logic [31:0] rv;

  always #5 clk = ~clk;

  card_host_ctrl i_card_host_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #2;
    got_go = cmd_go; got_abort = xfer_abort; got_txwr = fifo_tx_wr;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    d = bus_rdata; got_rxrd = fifo_rx_rd; got_resprd = resp_rd;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_irq(input logic [12:0] v);
    @(negedge clk); dp_irq_set = v;
    @(posedge clk); #1; dp_irq_set = '0;
  endtask

  task automatic pulse_stat(input logic [15:0] v);
    @(negedge clk); dp_stat_set = v;
    @(posedge clk); #1; dp_stat_set = '0;
  endtask

  function automatic logic exp_irq(input logic [12:0] req, input logic [12:0] msk, input logic dma);
    logic [12:0] m;
    m = msk | (dma ? 13'h0060 : 13'h0000);
    return |(req & ~m);
  endfunction

  function automatic logic [31:0] field_mask(input int sel, output logic [6:0] a);
    case (sel)
      0: begin a = 7'h08; return 32'h7;    end
      1: begin a = 7'h0C; return 32'hF;    end
      2: begin a = 7'h10; return 32'h3DFF; end
      3: begin a = 7'h14; return 32'h7F;   end
      4: begin a = 7'h18; return 32'hFFFF; end
      5: begin a = 7'h1C; return 32'hFFF;  end
      6: begin a = 7'h20; return 32'hFFFF; end
      7: begin a = 7'h28; return 32'h1FFF; end
      default: begin a = 7'h30; return 32'h3F; end
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [12:0] req_m, msk_m;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(7'h04, rv); chk("R1 status", rv, 0);
    rd(7'h2C, rv); chk("R1 request", rv, 0);
    rd(7'h10, rv); chk("R1 config", rv, 0);
    chk("R1 outputs", {irq, dma_rx_req, dma_tx_req}, 0);

    // R2 random write masks (clock off, so no launch)
    for (int i = 0; i < 24; i++) begin
      logic [6:0] a; logic [31:0] m, d, e;
      m = field_mask($urandom_range(0, 8), a);
      d = $urandom;
      e = (d & m) | ((a == 7'h30) ? 32'h40 : 32'h0);
      wr(a, d);
      rd(a, rv); chk("R2 masked readback", rv, e);
      if (a == 7'h20) begin rd(7'h4C, rv); chk("R3 blocks remaining", rv, e); end
    end
    wr(7'h28, 0);
    wr(7'h10, 0);
    chk("R6 no go with clock off", got_go, 0);
    chk("R6 abort on config write", got_abort, 1);

    // R3 argument halves and fixed reads
    wr(7'h34, 32'h1234ABCD); wr(7'h38, 32'hFFFF5678);
    rd(7'h34, rv); chk("R3 arg high", rv, 32'hABCD);
    rd(7'h38, rv); chk("R3 arg low", rv, 32'h5678);
    chk("R3 arg port", cmd_arg, 32'hABCD5678);
    wr(7'h34, 32'h1111);
    chk("R3 arg low kept", cmd_arg, 32'h11115678);
    wr(7'h30, 32'h25); rd(7'h30, rv); chk("R3 index or 0x40", rv, 32'h65);
    wr(7'h24, 32'hFFFF); rd(7'h24, rv); chk("R3 partial reads 0", rv, 0);
    wr(7'h48, 32'hFFFF); rd(7'h48, rv); chk("R3 read wait reads 0", rv, 0);
    rd(7'h00, rv); chk("R3 clkctl reads 0", rv, 0);
    wr(7'h08, 32'h5);
    wr(7'h50, 32'hFFFF_FFFF); wr(7'h4C, 32'h3);
    rd(7'h50, rv); chk("R3 unmapped reads 0", rv, 0);
    rd(7'h08, rv); chk("R3 unmapped write ignored", rv, 5);

    // R11 status set, R6 clear on config write with clock off
    pulse_stat(16'h3102);
    rd(7'h04, rv); chk("R11 status set (bit8 excluded)", rv, 32'h3002);
    wr(7'h04, 0); rd(7'h04, rv); chk("R3 status write ignored", rv, 32'h3002);
    wr(7'h10, 32'h0001);
    chk("R6 no go clock off", got_go, 0);
    rd(7'h04, rv); chk("R6 status cleared", rv, 0);

    // R7 launch on clock start with pending, R4 status
    wr(7'h00, 32'h2);
    chk("R7 go on start", got_go, 1);
    rd(7'h04, rv); chk("R4 clock running", rv, 32'h100);
    wr(7'h00, 32'h2);
    chk("R6 pending cleared after issue", got_go, 0);

    // stop-transfer gate
    pulse_stat(16'h0802);
    wr(7'h10, 32'h0400);
    chk("R6 halt: no go", got_go, 0);
    chk("R6 halt: abort", got_abort, 1);
    rd(7'h04, rv); chk("R6 halt keeps status", rv, 32'h0902);
    wr(7'h00, 32'h2);
    chk("R7 start with halt bit: no go", got_go, 0);
    wr(7'h10, 32'h0001);
    chk("R6 go with clock on", got_go, 1);
    rd(7'h04, rv); chk("R6 status keeps bit8", rv, 32'h100);

    // R5 stop clock, R8 masking
    wr(7'h00, 32'h1);
    chk("R5 abort on stop", got_abort, 1);
    rd(7'h04, rv); chk("R5 clock stopped", rv, 0);
    rd(7'h2C, rv); chk("R5 clock-off request", rv, 32'h10);
    chk("R8 irq unmasked", irq, 1);
    wr(7'h28, 32'h10); chk("R8 irq masked", irq, 0);
    wr(7'h2C, 0); rd(7'h2C, rv); chk("R3 request write ignored", rv, 32'h10);
    wr(7'h28, 0);
    wr(7'h00, 32'h2);
    rd(7'h2C, rv); chk("R4 clock-off request cleared", rv, 0);
    chk("R8 irq low", irq, 0);

    // R9 DMA routing and R10 FIFO passthrough
    pulse_irq(13'h0060);
    chk("R9 irq without dma", irq, 1);
    chk("R9 dma lines low", {dma_rx_req, dma_tx_req}, 0);
    wr(7'h10, 32'h0080);
    chk("R9 dma lines", {dma_rx_req, dma_tx_req}, 2'b11);
    chk("R9 irq masked by dma", irq, 0);
    bus_size = 2'd1;
    rd(7'h40, rv);
    chk("R10 rx data", rv, 32'hA5A5_1234);
    chk("R10 rx strobe", got_rxrd, 1);
    chk("R10 size", fifo_size, 2'd1);
    chk("R10 rx request cleared", {dma_rx_req, dma_tx_req}, 2'b01);
    wr(7'h44, 32'h77);
    chk("R10 tx strobe", got_txwr, 1);
    chk("R10 tx request cleared", dma_tx_req, 0);
    rd(7'h3C, rv);
    chk("R10 response data", rv, 32'hBEEF);
    chk("R10 response strobe", got_resprd, 1);

    // R11 set wins over same-cycle clear
    pulse_irq(13'h0020);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 7'h40; dp_irq_set = 13'h0020;
    @(posedge clk); #1; bus_rd = 1'b0; dp_irq_set = '0;
    chk("R11 set wins over clear", dma_rx_req, 1);
    rd(7'h40, rv);
    wr(7'h10, 0);

    // R5 start and stop together
    wr(7'h00, 32'h3);
    rd(7'h04, rv); chk("R5 both bits leaves clock off", rv, 0);
    rd(7'h2C, rv); chk("R5 both bits sets clock-off", rv, 32'h10);

    // R8 random requests and masks
    req_m = 13'h0010; msk_m = 13'h0;
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 1) == 0) begin
        logic [12:0] s;
        s = 13'($urandom) & 13'($urandom) & 13'($urandom);
        pulse_irq(s);
        req_m = req_m | s;
      end else begin
        msk_m = 13'($urandom);
        wr(7'h28, {19'h0, msk_m});
      end
      chk("R8 random irq", irq, exp_irq(req_m, msk_m, 1'b0));
    end
    rd(7'h2C, rv); chk("R8 request vector", rv, {19'h0, req_m});

    finish_run();
  end
endmodule